// File: doc/BRIEF.md
# Byte-Wide Access Bridge for 16-bit Registers

This block sits between an 8-bit processor bus and four 16-bit peripheral registers: a counter, two compare registers and a capture register. The bus reaches each register as two byte addresses. One shared 8-bit temporary byte lets the bus move a whole 16-bit value in two accesses without tearing.

On reads, software takes the low byte first. That access returns the live low byte and, on the same clock edge, copies the register's high byte into the temporary byte. The next high-byte read returns that copy, so both halves come from the same instant. On writes, software writes the high byte first, which only loads the temporary byte. The low-byte write then presents the temporary byte and the new low byte together as one 16-bit value, with a single-cycle write enable to the target. The registers themselves and any interrupt masking around these sequences are outside the block.

Each bus cycle is decoded into one access kind: `ACC_IDLE` (no strobe), `ACC_RD_LO`, `ACC_RD_HI`, `ACC_WR_LO`, `ACC_WR_HI`, or `ACC_UNMAP` (a strobe to an address outside the map). The temporary byte is the only stored state. It moves on exactly two transitions: `ACC_RD_LO` loads it from the selected register's high byte, and `ACC_WR_HI` loads it from the bus write data. Every other kind leaves it unchanged. Reset returns it to zero.

Top module: `bbr_top`

## Requirements
- R1: A read of a low-byte address returns that register's live low byte in the same cycle, and at the clock edge loads the register's high byte into the temporary byte. Address map: counter 0 (low) / 1 (high), compare A 2/3, compare B 4/5, capture 6/7.
- R2: A read of a high-byte address returns the temporary byte, not the register's live high byte. A low-then-high read pair therefore returns the high byte as it was at the low read.
- R3: A write to a high-byte address loads the write data into the temporary byte and raises no write enable.
- R4: A write to the low byte of the counter, compare A or compare B raises only that register's write enable, for that one cycle. `reg_wdata` carries {temporary byte, write data} in the same cycle.
- R5: All registers share one temporary byte. The latest low-byte read or high-byte write to any register decides what the next high-byte read returns and what the next low-byte write commits.
- R6: A write to the capture low byte (address 6) raises no write enable. A write to the capture high byte (address 7) still loads the temporary byte.
- R7: A read or write at an address of 8 or above returns 0, raises no write enable and leaves the temporary byte unchanged.
- R8: While `bus_rd` is low, `bus_rdata` is 0.
- R9: When `bus_rd` and `bus_wr` are both high, the cycle is treated purely as a read and the write is ignored.
- R10: Reset clears the temporary byte to 0, so a high-byte read straight after reset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (4) | Byte address |
| bus_wdata | input | 8 | Write data byte |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_rdata | output | 8 | Read data byte, combinational |
| cnt_q | input | 16 | Live counter value |
| cmpa_q | input | 16 | Live compare A value |
| cmpb_q | input | 16 | Live compare B value |
| cap_q | input | 16 | Live capture value |
| reg_wdata | output | 16 | Commit data: {temporary byte, write byte} |
| cnt_we | output | 1 | Counter write enable |
| cmpa_we | output | 1 | Compare A write enable |
| cmpb_we | output | 1 | Compare B write enable |

## Verification
The bench changes the live counter value between the low and high reads. A bridge that passed the live high byte through would return the new value instead of the snapshot. It interleaves low reads of two registers before one high read, to show that a design with one temporary byte per register would return the wrong byte. It also drives unmapped addresses, a write to the read-only capture register, and simultaneous read and write strobes. A leaky decoder would disturb the temporary byte or raise an enable in those cases. Finally, it resets between a high write and its low write, to show that a stale temporary byte would be committed.

// File: rtl/bbr_pkg.sv
package bbr_pkg;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 2 * BYTE_W;
    localparam int NUM_REG = 4;
    localparam int IDX_W   = $clog2(NUM_REG);

    // index 0 counter, 1 compare A, 2 compare B, 3 capture (read-only)
    localparam logic [NUM_REG-1:0] WRITABLE = 4'b0111;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_RD_LO,
        ACC_RD_HI,
        ACC_WR_LO,
        ACC_WR_HI,
        ACC_UNMAP
    } acc_e;
endpackage

// File: rtl/bbr_decode.sv
module bbr_decode
    import bbr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               rd,
    input  logic               wr,
    output acc_e               kind,
    output logic [NUM_REG-1:0] sel
);
    localparam int MAP_SPAN = 2 * NUM_REG;

    logic             mapped;
    logic [IDX_W-1:0] idx;

    assign mapped = (addr < ADDR_W'(MAP_SPAN));
    assign idx    = addr[IDX_W:1];

    always_comb begin
        kind = ACC_IDLE;
        sel  = '0;
        if (rd || wr) begin
            if (!mapped) begin
                kind = ACC_UNMAP;
            end else begin
                sel[idx] = 1'b1;
                // read strobe takes priority over write strobe
                unique case ({rd, addr[0]})
                    2'b10:   kind = ACC_RD_LO;
                    2'b11:   kind = ACC_RD_HI;
                    2'b00:   kind = ACC_WR_LO;
                    default: kind = ACC_WR_HI;
                endcase
            end
        end
    end
endmodule

// File: rtl/bbr_temp.sv
module bbr_temp
    import bbr_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  acc_e                        kind,
    input  logic [NUM_REG-1:0]          sel,
    input  logic [NUM_REG*BYTE_W-1:0]   live_hi,
    input  logic [BYTE_W-1:0]           wdata,
    output logic [BYTE_W-1:0]           temp_q
);
    logic [BYTE_W-1:0] pick_hi;

    always_comb begin
        pick_hi = '0;
        for (int i = 0; i < NUM_REG; i++) begin
            if (sel[i]) pick_hi = live_hi[i*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            temp_q <= '0;
        end else begin
            unique case (kind)
                ACC_RD_LO: temp_q <= pick_hi;
                ACC_WR_HI: temp_q <= wdata;
                default:   temp_q <= temp_q;
            endcase
        end
    end

    // R7
    unmap_keeps_temp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_UNMAP) |=> $stable(temp_q));

    // R10
    reset_clears_temp_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (temp_q == '0));
endmodule

// File: rtl/bbr_rdmux.sv
module bbr_rdmux
    import bbr_pkg::*;
(
    input  acc_e                        kind,
    input  logic [NUM_REG-1:0]          sel,
    input  logic [NUM_REG*BYTE_W-1:0]   live_lo,
    input  logic [BYTE_W-1:0]           temp_q,
    output logic [BYTE_W-1:0]           rdata
);
    always_comb begin
        rdata = '0;
        unique case (kind)
            ACC_RD_LO: begin
                for (int i = 0; i < NUM_REG; i++) begin
                    if (sel[i]) rdata = live_lo[i*BYTE_W +: BYTE_W];
                end
            end
            ACC_RD_HI: rdata = temp_q;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/bbr_top.sv
module bbr_top
    import bbr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [7:0]        bus_rdata,
    input  logic [15:0]       cnt_q,
    input  logic [15:0]       cmpa_q,
    input  logic [15:0]       cmpb_q,
    input  logic [15:0]       cap_q,
    output logic [15:0]       reg_wdata,
    output logic              cnt_we,
    output logic              cmpa_we,
    output logic              cmpb_we
);
    acc_e                      kind;
    logic [NUM_REG-1:0]        sel;
    logic [NUM_REG-1:0]        we_vec;
    logic [BYTE_W-1:0]         temp_q;
    logic [NUM_REG*BYTE_W-1:0] live_hi;
    logic [NUM_REG*BYTE_W-1:0] live_lo;

    assign live_hi = {cap_q[15:8], cmpb_q[15:8], cmpa_q[15:8], cnt_q[15:8]};
    assign live_lo = {cap_q[7:0],  cmpb_q[7:0],  cmpa_q[7:0],  cnt_q[7:0]};

    bbr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .kind (kind),
        .sel  (sel)
    );

    bbr_temp u_temp (
        .clk     (clk),
        .rst_n   (rst_n),
        .kind    (kind),
        .sel     (sel),
        .live_hi (live_hi),
        .wdata   (bus_wdata),
        .temp_q  (temp_q)
    );

    bbr_rdmux u_rdmux (
        .kind    (kind),
        .sel     (sel),
        .live_lo (live_lo),
        .temp_q  (temp_q),
        .rdata   (bus_rdata)
    );

    generate
        for (genvar g = 0; g < NUM_REG; g++) begin : g_commit
            if (WRITABLE[g]) begin : g_rw
                assign we_vec[g] = (kind == ACC_WR_LO) && sel[g];
            end else begin : g_ro
                assign we_vec[g] = 1'b0;
            end
        end
    endgenerate

    assign reg_wdata = {temp_q, bus_wdata};
    assign cnt_we    = we_vec[0];
    assign cmpa_we   = we_vec[1];
    assign cmpb_we   = we_vec[2];

    // R2
    snapshot_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(1) && $past(bus_rd && bus_addr == ADDR_W'(0)))
        |-> (bus_rdata == $past(cnt_q[15:8])));

    // R4
    commit_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && bus_addr == ADDR_W'(0)
         && $past(bus_wr && !bus_rd && bus_addr == ADDR_W'(1)))
        |-> (cnt_we && reg_wdata == {$past(bus_wdata), bus_wdata}));

    // R4
    single_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_vec));

    // R6
    capture_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(6)) |-> !(cnt_we || cmpa_we || cmpb_we || we_vec[3]));

    // R8
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == 8'h00));

    // R3
    hi_write_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[0]) |-> !(cnt_we || cmpa_we || cmpb_we));
endmodule

// File: tb/bbr_top_tb.sv
module bbr_top_tb;
    localparam int CLK_P = 10;
    localparam int NV    = 24;

    // {req[44:41], rd[40], wr[39], addr[38:35], wd[34:27], erd[26:19], ewe[18:16], ewd[15:0]}
    // ewe = {cmpb, cmpa, cnt}; live: cnt 1234, cmpa ABCD, cmpb 5A0F, cap C3E1
    localparam logic [44:0] VEC [0:NV-1] = '{
        {4'd10, 1'b1, 1'b0, 4'd1,  8'h00, 8'h00, 3'b000, 16'h0000}, // R10 hi after reset
        {4'd1,  1'b1, 1'b0, 4'd0,  8'h00, 8'h34, 3'b000, 16'h0000}, // R1
        {4'd2,  1'b1, 1'b0, 4'd1,  8'h00, 8'h12, 3'b000, 16'h0000}, // R2
        {4'd1,  1'b1, 1'b0, 4'd2,  8'h00, 8'hCD, 3'b000, 16'h0000}, // R1
        {4'd2,  1'b1, 1'b0, 4'd3,  8'h00, 8'hAB, 3'b000, 16'h0000}, // R2
        {4'd1,  1'b1, 1'b0, 4'd6,  8'h00, 8'hE1, 3'b000, 16'h0000}, // R1
        {4'd2,  1'b1, 1'b0, 4'd7,  8'h00, 8'hC3, 3'b000, 16'h0000}, // R2
        {4'd7,  1'b1, 1'b0, 4'd9,  8'h00, 8'h00, 3'b000, 16'h0000}, // R7
        {4'd7,  1'b1, 1'b0, 4'd7,  8'h00, 8'hC3, 3'b000, 16'h0000}, // R7
        {4'd7,  1'b0, 1'b1, 4'd9,  8'h77, 8'h00, 3'b000, 16'h0000}, // R7
        {4'd7,  1'b1, 1'b0, 4'd7,  8'h00, 8'hC3, 3'b000, 16'h0000}, // R7
        {4'd3,  1'b0, 1'b1, 4'd1,  8'h5E, 8'h00, 3'b000, 16'h0000}, // R3
        {4'd4,  1'b0, 1'b1, 4'd0,  8'h21, 8'h00, 3'b001, 16'h5E21}, // R4
        {4'd3,  1'b0, 1'b1, 4'd5,  8'h99, 8'h00, 3'b000, 16'h0000}, // R3
        {4'd4,  1'b0, 1'b1, 4'd4,  8'h88, 8'h00, 3'b100, 16'h9988}, // R4
        {4'd3,  1'b0, 1'b1, 4'd3,  8'h11, 8'h00, 3'b000, 16'h0000}, // R3
        {4'd4,  1'b0, 1'b1, 4'd2,  8'h22, 8'h00, 3'b010, 16'h1122}, // R4
        {4'd6,  1'b0, 1'b1, 4'd7,  8'h44, 8'h00, 3'b000, 16'h0000}, // R6
        {4'd6,  1'b0, 1'b1, 4'd6,  8'h55, 8'h00, 3'b000, 16'h0000}, // R6
        {4'd6,  1'b1, 1'b0, 4'd1,  8'h00, 8'h44, 3'b000, 16'h0000}, // R6
        {4'd8,  1'b0, 1'b0, 4'd0,  8'h00, 8'h00, 3'b000, 16'h0000}, // R8
        {4'd9,  1'b1, 1'b1, 4'd0,  8'hFF, 8'h34, 3'b000, 16'h0000}, // R9
        {4'd9,  1'b1, 1'b0, 4'd1,  8'h00, 8'h12, 3'b000, 16'h0000}, // R9
        {4'd7,  1'b1, 1'b0, 4'd15, 8'h00, 8'h00, 3'b000, 16'h0000}  // R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_rdata;
    logic [15:0] cnt_q = 16'h1234;
    logic [15:0] cmpa_q = 16'hABCD;
    logic [15:0] cmpb_q = 16'h5A0F;
    logic [15:0] cap_q = 16'hC3E1;
    logic [15:0] reg_wdata;
    logic        cnt_we, cmpa_we, cmpb_we;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    bbr_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
        .cnt_q(cnt_q), .cmpa_q(cmpa_q), .cmpb_q(cmpb_q), .cap_q(cap_q),
        .reg_wdata(reg_wdata), .cnt_we(cnt_we), .cmpa_we(cmpa_we), .cmpb_we(cmpb_we)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // drive at negedge, sample 1 time unit later, well before the next rising edge
    task automatic drive(input logic rd, input logic wr, input logic [3:0] a,
                         input logic [7:0] d);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
        #1;
    endtask

    initial begin
        #(CLK_P * 5000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R10", "rdata in reset", {8'h00, bus_rdata}, 16'h0000);
        check("R10", "enables in reset", {13'd0, cmpb_we, cmpa_we, cnt_we}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            drive(VEC[v][40], VEC[v][39], VEC[v][38:35], VEC[v][34:27]);
            check($sformatf("R%0d", VEC[v][44:41]), $sformatf("vec %0d rdata", v),
                  {8'h00, bus_rdata}, {8'h00, VEC[v][26:19]});
            check($sformatf("R%0d", VEC[v][44:41]), $sformatf("vec %0d enables", v),
                  {13'd0, cmpb_we, cmpa_we, cnt_we}, {13'd0, VEC[v][18:16]});
            if (VEC[v][18:16] != 3'b000)
                check($sformatf("R%0d", VEC[v][44:41]), $sformatf("vec %0d wdata", v),
                      reg_wdata, VEC[v][15:0]);
        end

        // R2 snapshot survives a change of the live value between the two reads
        drive(1'b1, 1'b0, 4'd0, 8'h00);
        check("R1", "snapshot lo", {8'h00, bus_rdata}, 16'h0034);
        @(negedge clk);
        cnt_q = 16'h9999;
        bus_rd = 1'b1; bus_addr = 4'd1;
        #1;
        check("R2", "snapshot hi after live change", {8'h00, bus_rdata}, 16'h0012);

        // R5 interleaved low reads: the last one owns the temporary byte
        drive(1'b1, 1'b0, 4'd0, 8'h00);
        drive(1'b1, 1'b0, 4'd4, 8'h00);
        drive(1'b1, 1'b0, 4'd1, 8'h00);
        check("R5", "counter hi after compare B lo", {8'h00, bus_rdata}, 16'h005A);

        // R5 a high write to compare A is committed by a low write to the counter
        drive(1'b0, 1'b1, 4'd3, 8'hE7);
        drive(1'b0, 1'b1, 4'd0, 8'h01);
        check("R5", "cross-register commit data", reg_wdata, 16'hE701);
        check("R5", "cross-register commit enable", {13'd0, cmpb_we, cmpa_we, cnt_we}, 16'h0001);

        // R10 reset between a high write and its low write
        drive(1'b0, 1'b1, 4'd1, 8'h66);
        drive(1'b0, 1'b0, 4'd0, 8'h00);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 1'b1, 4'd0, 8'h21);
        check("R10", "commit after reset", reg_wdata, 16'h0021);
        check("R10", "commit enable after reset", {13'd0, cmpb_we, cmpa_we, cnt_we}, 16'h0001);

        drive(1'b0, 1'b0, 4'd0, 8'h00);
        check("R8", "idle rdata", {8'h00, bus_rdata}, 16'h0000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule